// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front End

This block is the host-side register bank for a pair of UART channels. Each channel keeps its own line control, modem control and alternate function settings, a pair of divisor bytes and three data-side registers. A host reaches them through a small strobe bus: a 3-bit address, a channel-select input, a write strobe and a read strobe. A divisor-select bit in each channel's line control register decides whether the three lowest addresses reach the data-side registers or the divisor bytes.

A shared broadcast bit lets one host write land in both channels at once, which halves the setup time when both channels are configured alike. Reads always come from the channel named by the select input. The block also drives three pins per channel: the transmit line, which a break bit can hold low; an active-low terminal-ready output; and an active-low multifunction output whose source is picked by a two-bit field. The serializer output, the baud clock and the receiver-ready flag come in as plain inputs.

Top module: `duart_regfront`

## Requirements
- R1: After reset every register reads 0 on both channels, `dtr_n` and `mf_n` are 1, and `tx_out` follows `ser_tx_in`.
- R2: Address map per channel: 3 = line control, 4 = modem control, 5 = alternate function; 0..2 reach data-side registers 0..2 when line control bit 7 is 0; addresses 6 and 7 read 0 and writes to them change nothing.
- R3: With line control bit 7 at 1, address 0 reaches the divisor low byte, address 1 the divisor high byte, and address 2 reads 0 with writes ignored; the data-side registers keep their values.
- R4: With broadcast off, a write changes only the channel named by `host_chan` (0 = first channel, 1 = second).
- R5: Alternate function bit 0 is one broadcast bit shared by both channels; a write to address 5 through either channel sets or clears it, and address 5 of either channel reads it back in bit 0.
- R6: With broadcast on, one write updates the addressed register in both channels, each channel decoding addresses 0..2 with its own line control bit 7.
- R7: With broadcast on, reads still return only the channel named by `host_chan`.
- R8: Alternate function bits 7:3 always read 0 whatever was written.
- R9: Line control bit 6 at 1 holds that channel's `tx_out` at 0 until the bit is written back to 0; at 0, `tx_out` equals `ser_tx_in`.
- R10: `dtr_n` is the inverse of modem control bit 0.
- R11: Alternate function bits 2:1 pick `mf_n`: 00 gives the inverse of modem control bit 3, 01 gives `baud_clk_in`, 10 gives 1, 11 gives the inverse of `rx_ready_in`.
- R12: `host_rdata` is registered: it shows the addressed register on the cycle after `host_re` and holds its value while `host_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Single-cycle write strobe |
| host_re | input | 1 | Single-cycle read strobe |
| host_addr | input | 3 | Register address |
| host_chan | input | 1 | Channel select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| ser_tx_in | input | 2 | Serializer output per channel |
| baud_clk_in | input | 2 | Baud clock per channel |
| rx_ready_in | input | 2 | Receiver data-ready per channel |
| tx_out | output | 2 | Transmit line per channel |
| dtr_n | output | 2 | Active-low terminal-ready per channel |
| mf_n | output | 2 | Active-low multifunction output per channel |

## Verification
A corrupted register shows up at `host_rdata` one cycle after the next read of its address, and a wrong break, modem or multifunction-select bit shows on `tx_out`, `dtr_n` or `mf_n` in the cycle right after the write that set it. A stuck broadcast bit shows as the unselected channel changing, visible at the next read of that channel or on its pins at once. A divisor-select bit held in the wrong state shows as data-side and divisor values swapping places on read-back.

// File: rtl/duart_regfront_pkg.sv
package duart_regfront_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_REGS = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA0  = 3'd0,
    RA_DATA1  = 3'd1,
    RA_DATA2  = 3'd2,
    RA_LINE   = 3'd3,
    RA_MODEM  = 3'd4,
    RA_ALTF   = 3'd5,
    RA_SPARE6 = 3'd6,
    RA_SPARE7 = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    MF_OP2   = 2'b00,
    MF_BAUD  = 2'b01,
    MF_RSVD  = 2'b10,
    MF_RXRDY = 2'b11
  } mf_sel_e;

  localparam int LC_DIV_SEL = 7;
  localparam int LC_BREAK   = 6;
  localparam int MC_DTR     = 0;
  localparam int MC_OP2     = 3;
  localparam int AF_BCAST   = 0;
  localparam int AF_MF_LO   = 1;
  localparam int AF_MF_HI   = 2;

endpackage

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_regfront_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              bcast_i,
  output logic              break_o,
  output logic              dtr_o,
  output logic              op2_o,
  output logic [1:0]        mf_sel_o,
  output logic [DW-1:0]     rd_data_o
);

  logic [DW-1:0] dreg_q [DATA_REGS];
  logic [DW-1:0] dreg_n [DATA_REGS];
  logic [DW-1:0] div_lo_q, div_lo_n;
  logic [DW-1:0] div_hi_q, div_hi_n;
  logic [DW-1:0] line_q, line_n;
  logic [DW-1:0] modem_q, modem_n;
  logic [1:0]    mfsel_q, mfsel_n;

  // next-state for the whole bank
  always_comb begin
    for (int i = 0; i < DATA_REGS; i++) dreg_n[i] = dreg_q[i];
    div_lo_n = div_lo_q;
    div_hi_n = div_hi_q;
    line_n   = line_q;
    modem_n  = modem_q;
    mfsel_n  = mfsel_q;
    case (addr_i)
      RA_DATA0, RA_DATA1, RA_DATA2: begin
        if (line_q[LC_DIV_SEL]) begin
          if (addr_i == RA_DATA0)      div_lo_n = wdata_i;
          else if (addr_i == RA_DATA1) div_hi_n = wdata_i;
        end else begin
          dreg_n[addr_i] = wdata_i;
        end
      end
      RA_LINE:  line_n  = wdata_i;
      RA_MODEM: modem_n = wdata_i;
      RA_ALTF:  mfsel_n = wdata_i[AF_MF_HI:AF_MF_LO];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_REGS; i++) dreg_q[i] <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      line_q   <= '0;
      modem_q  <= '0;
      mfsel_q  <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < DATA_REGS; i++) dreg_q[i] <= dreg_n[i];
      div_lo_q <= div_lo_n;
      div_hi_q <= div_hi_n;
      line_q   <= line_n;
      modem_q  <= modem_n;
      mfsel_q  <= mfsel_n;
    end
  end

  // read selection, same decode as the write side
  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      RA_DATA0, RA_DATA1, RA_DATA2: begin
        if (line_q[LC_DIV_SEL]) begin
          if (addr_i == RA_DATA0)      rd_data_o = div_lo_q;
          else if (addr_i == RA_DATA1) rd_data_o = div_hi_q;
        end else begin
          rd_data_o = dreg_q[addr_i];
        end
      end
      RA_LINE:  rd_data_o = line_q;
      RA_MODEM: rd_data_o = modem_q;
      RA_ALTF: begin
        rd_data_o[AF_MF_HI:AF_MF_LO] = mfsel_q;
        rd_data_o[AF_BCAST]          = bcast_i;
      end
      default: ;
    endcase
  end

  assign break_o  = line_q[LC_BREAK];
  assign dtr_o    = modem_q[MC_DTR];
  assign op2_o    = modem_q[MC_OP2];
  assign mf_sel_o = mfsel_q;

endmodule

// File: rtl/duart_pin_drive.sv
module duart_pin_drive
  import duart_regfront_pkg::*;
(
  input  logic       break_i,
  input  logic       dtr_i,
  input  logic       op2_i,
  input  logic [1:0] mf_sel_i,
  input  logic       ser_tx_i,
  input  logic       baud_clk_i,
  input  logic       rx_ready_i,
  output logic       tx_o,
  output logic       dtr_n_o,
  output logic       mf_n_o
);

  assign tx_o    = break_i ? 1'b0 : ser_tx_i;
  assign dtr_n_o = ~dtr_i;

  always_comb begin
    case (mf_sel_e'(mf_sel_i))
      MF_OP2:   mf_n_o = ~op2_i;
      MF_BAUD:  mf_n_o = baud_clk_i;
      MF_RXRDY: mf_n_o = ~rx_ready_i;
      default:  mf_n_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/duart_regfront.sv
module duart_regfront
  import duart_regfront_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW = 8,
  localparam int SELW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [SELW-1:0]   host_chan,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [NUM_CH-1:0] ser_tx_in,
  input  logic [NUM_CH-1:0] baud_clk_in,
  input  logic [NUM_CH-1:0] rx_ready_in,
  output logic [NUM_CH-1:0] tx_out,
  output logic [NUM_CH-1:0] dtr_n,
  output logic [NUM_CH-1:0] mf_n
);

  logic          cw_q, cw_n, cw_en;
  logic [DW-1:0] ch_rd [NUM_CH];
  logic [DW-1:0] rdata_q, rdata_n;

  // shared broadcast bit, reachable from any channel
  assign cw_en = host_we && (host_addr == RA_ALTF);
  assign cw_n  = host_wdata[AF_BCAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cw_q <= 1'b0;
    else if (cw_en) cw_q <= cw_n;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic       hit;
    logic       brk, dtr, op2;
    logic [1:0] msel;

    assign hit = host_we && (cw_q || (host_chan == SELW'(c)));

    duart_chan_regs #(.DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (hit),
      .addr_i    (host_addr),
      .wdata_i   (host_wdata),
      .bcast_i   (cw_q),
      .break_o   (brk),
      .dtr_o     (dtr),
      .op2_o     (op2),
      .mf_sel_o  (msel),
      .rd_data_o (ch_rd[c])
    );

    duart_pin_drive u_pins (
      .break_i    (brk),
      .dtr_i      (dtr),
      .op2_i      (op2),
      .mf_sel_i   (msel),
      .ser_tx_i   (ser_tx_in[c]),
      .baud_clk_i (baud_clk_in[c]),
      .rx_ready_i (rx_ready_in[c]),
      .tx_o       (tx_out[c]),
      .dtr_n_o    (dtr_n[c]),
      .mf_n_o     (mf_n[c])
    );
  end

  // read path follows the select input only
  always_comb begin
    rdata_n = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (host_chan == SELW'(c)) rdata_n = ch_rd[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_re) rdata_q <= rdata_n;
  end

  assign host_rdata = rdata_q;

endmodule

// File: rtl/duart_regfront_chk.sv
module duart_regfront_chk
  import duart_regfront_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SELW = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic              host_re,
  input logic [ADDR_W-1:0] host_addr,
  input logic [SELW-1:0]   host_chan,
  input logic              wd_bcast,
  input logic              wd_break,
  input logic              wd_dtr,
  input logic [7:0]        host_rdata,
  input logic [NUM_CH-1:0] tx_out,
  input logic [NUM_CH-1:0] dtr_n,
  input logic              cw_q
);

  // R12: read data holds while no read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(host_rdata));

  // R8: reserved alternate function bits read back as zero
  a_r8_afr_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && host_addr == RA_ALTF) |=> (host_rdata[7:3] == 5'd0));

  // R5: broadcast bit follows any alternate function write
  a_r5_bcast_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == RA_ALTF) |=> (cw_q == $past(wd_bcast)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R9: break written to a channel forces its transmit line low
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == RA_LINE && wd_break &&
       (cw_q || host_chan == SELW'(c))) |=> (tx_out[c] == 1'b0));

    // R10 / R6: modem write reaches every targeted channel's ready pin
    a_r10_dtr_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == RA_MODEM && (cw_q || host_chan == SELW'(c)))
      |=> (dtr_n[c] == !$past(wd_dtr)));
  end

endmodule

bind duart_regfront duart_regfront_chk #(.NUM_CH(NUM_CH), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_re    (host_re),
  .host_addr  (host_addr),
  .host_chan  (host_chan),
  .wd_bcast   (host_wdata[0]),
  .wd_break   (host_wdata[6]),
  .wd_dtr     (host_wdata[0]),
  .host_rdata (host_rdata[7:0]),
  .tx_out     (tx_out),
  .dtr_n      (dtr_n),
  .cw_q       (cw_q)
);

// File: tb/duart_regfront_bench.sv
module duart_regfront_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic       host_re = 1'b0;
  logic [2:0] host_addr = '0;
  logic [0:0] host_chan = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [1:0] ser_tx_in = '0;
  logic [1:0] baud_clk_in = '0;
  logic [1:0] rx_ready_in = '0;
  logic [1:0] tx_out, dtr_n, mf_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_dreg [2][3];
  logic [7:0] m_dlo [2];
  logic [7:0] m_dhi [2];
  logic [7:0] m_lcr [2];
  logic [7:0] m_mcr [2];
  logic [1:0] m_mf [2];
  logic       m_cw;

  duart_regfront u_duart_regfront (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_chan(host_chan), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ser_tx_in(ser_tx_in), .baud_clk_in(baud_clk_in),
    .rx_ready_in(rx_ready_in), .tx_out(tx_out), .dtr_n(dtr_n), .mf_n(mf_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  function automatic logic [7:0] exp_rd(int c, int a);
    case (a)
      0, 1, 2: begin
        if (m_lcr[c][7]) return (a == 0) ? m_dlo[c] : (a == 1) ? m_dhi[c] : 8'h00;
        return m_dreg[c][a];
      end
      3: return m_lcr[c];
      4: return m_mcr[c];
      5: return {5'b0, m_mf[c], m_cw};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_mf(int c);
    case (m_mf[c])
      2'b00: return ~m_mcr[c][3];
      2'b01: return baud_clk_in[c];
      2'b10: return 1'b1;
      default: return ~rx_ready_in[c];
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int c, input logic [7:0] d);
    bit hit [2];
    @(negedge clk);
    if (m_cw && a <= 2 && m_lcr[0][7] != m_lcr[1][7]) begin
      n_chk++; n_fail++;
      $display("FAIL R6: broadcast to address %0d with divisor-select actual %b/%b expected equal",
               a, m_lcr[0][7], m_lcr[1][7]);
    end
    host_we = 1'b1; host_addr = 3'(a); host_chan = 1'(c); host_wdata = d;
    for (int ch = 0; ch < 2; ch++) hit[ch] = m_cw || (c == ch);
    for (int ch = 0; ch < 2; ch++) begin
      if (hit[ch]) begin
        case (a)
          0, 1, 2: begin
            if (m_lcr[ch][7]) begin
              if (a == 0) m_dlo[ch] = d;
              else if (a == 1) m_dhi[ch] = d;
            end else m_dreg[ch][a] = d;
          end
          3: m_lcr[ch] = d;
          4: m_mcr[ch] = d;
          5: m_mf[ch] = d[2:1];
          default: ;
        endcase
      end
    end
    if (a == 5) m_cw = d[0];
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int c);
    @(negedge clk);
    host_re = 1'b1; host_addr = 3'(a); host_chan = 1'(c);
    @(negedge clk);
    host_re = 1'b0;
    chk(req, host_rdata, exp_rd(c, a));
  endtask

  task automatic pins_chk();
    ser_tx_in = 2'($urandom); baud_clk_in = 2'($urandom); rx_ready_in = 2'($urandom);
    #1;
    for (int ch = 0; ch < 2; ch++) begin
      chk("R9 tx_out", {7'b0, tx_out[ch]}, {7'b0, m_lcr[ch][6] ? 1'b0 : ser_tx_in[ch]});
      chk("R10 dtr_n", {7'b0, dtr_n[ch]}, {7'b0, ~m_mcr[ch][0]});
      chk("R11 mf_n", {7'b0, mf_n[ch]}, {7'b0, exp_mf(ch)});
    end
  endtask

  initial begin
    void'($urandom(32'h0000_2752));
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < 3; i++) m_dreg[ch][i] = '0;
      m_dlo[ch] = '0; m_dhi[ch] = '0; m_lcr[ch] = '0; m_mcr[ch] = '0; m_mf[ch] = '0;
    end
    m_cw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int ch = 0; ch < 2; ch++)
      for (int a = 0; a < 8; a++) rd_chk("R1 reset value", a, ch);
    pins_chk();
    chk("R1 dtr_n idle", {6'b0, dtr_n}, 8'h03);
    chk("R1 mf_n idle", {6'b0, mf_n}, 8'h03);

    // R2: map and spare addresses
    wr(0, 0, 8'h11); wr(1, 0, 8'h22); wr(2, 0, 8'h33);
    wr(4, 0, 8'h08); wr(6, 0, 8'hAA); wr(7, 1, 8'h55);
    for (int a = 0; a < 8; a++) rd_chk("R2 address map", a, 0);
    rd_chk("R2 spare write", 6, 1);

    // R4: channel isolation
    wr(0, 1, 8'h5A);
    rd_chk("R4 other channel untouched", 0, 0);
    rd_chk("R4 selected channel written", 0, 1);

    // R3: divisor select
    wr(3, 0, 8'h80);
    wr(0, 0, 8'hC3); wr(1, 0, 8'h3C); wr(2, 0, 8'hEE);
    rd_chk("R3 divisor low", 0, 0);
    rd_chk("R3 divisor high", 1, 0);
    rd_chk("R3 address 2 reads zero", 2, 0);
    wr(3, 0, 8'h00);
    rd_chk("R3 data reg 0 kept", 0, 0);
    rd_chk("R3 data reg 2 kept", 2, 0);

    // R5: shared broadcast bit set through second channel
    wr(5, 1, 8'h01);
    rd_chk("R5 bit seen on first channel", 5, 0);
    rd_chk("R5 bit seen on second channel", 5, 1);

    // R6 / R7: broadcast write, reads follow select
    wr(4, 0, 8'h01);
    pins_chk();
    chk("R6 both ready pins low", {6'b0, dtr_n}, 8'h00);
    rd_chk("R7 read first channel", 0, 0);
    rd_chk("R7 read second channel", 0, 1);
    wr(3, 1, 8'h80);
    wr(0, 0, 8'h9D);
    rd_chk("R6 divisor both A", 0, 0);
    rd_chk("R6 divisor both B", 0, 1);
    wr(3, 0, 8'h00);
    wr(5, 0, 8'h00);
    wr(1, 1, 8'h77);
    rd_chk("R5 cleared via first channel", 5, 1);
    rd_chk("R4 no broadcast after clear", 1, 0);

    // R8: reserved bits
    wr(5, 0, 8'hF8);
    rd_chk("R8 reserved bits zero", 5, 0);

    // R9 / R11: break and every source select
    wr(3, 1, 8'h40); pins_chk();
    chk("R9 break holds low", {7'b0, tx_out[1]}, 8'h00);
    wr(3, 1, 8'h00); pins_chk();
    for (int s = 0; s < 4; s++) begin
      wr(5, 0, 8'(s << 1));
      wr(5, 1, 8'((3 - s) << 1));
      pins_chk();
      rd_chk("R11 select readback", 5, 0);
    end

    // R12: hold while idle
    rd_chk("R12 fresh read", 3, 1);
    begin
      logic [7:0] held;
      held = host_rdata;
      wr(3, 1, 8'h12);
      @(negedge clk);
      chk("R12 hold without strobe", host_rdata, held);
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int a, c, op;
      logic [7:0] d;
      a = int'($urandom % 8); c = int'($urandom % 2); op = int'($urandom % 3);
      d = 8'($urandom);
      if (op < 2) begin
        if (m_cw && a <= 2 && m_lcr[0][7] != m_lcr[1][7]) a = 3;
        wr(a, c, d);
      end else begin
        rd_chk("R2 random read", a, c);
      end
      pins_chk();
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule